// File: doc/BRIEF.md
# Clock-Crossing Register Bridge with Batched Release

This block carries three configuration registers from a fast bus clock into a slow peripheral clock. The three registers are a configuration word, a command word and a counter limit word. A write on the fast side lands in a fast-side shadow and raises a busy flag for that register. The value is then carried across in a toggle handshake. The busy flag drops once the slow side has acknowledged that it applied the value. While the flag is up, a further non-frozen write to the same register is held off by deasserting `wr_ready`.

A freeze input lets software stage several registers without any of them crossing. When freeze drops, every staged register leaves in one transfer and updates the slow-side outputs on the same slow clock edge. All registers share one transfer channel, so writes made in a given order are applied in that order. A limit written before a configuration change therefore never arrives after it. One bit of the configuration word, the counter-reset bit, does not wait for the crossing. It is driven straight from the fast-side shadow flop as `cnt_rst`, but writing it still counts as a configuration write for the busy flag. Command bits appear on the slow side as one-cycle pulses.

Top module: `xrb_bridge`

## Requirements
- R1: After reset, `busy` is 0, `wr_ready` is 1, and `cnt_rst`, `s_cfg`, `s_cmd` and `s_limit` are all 0.
- R2: `wr_sel` encodes the register: 0 is configuration, 1 is command and 2 is limit. `busy` uses the same bit index. A write accepted on a fast edge (`wr_en` and `wr_ready` both high) shows its busy bit set after that edge.
- R3: With freeze low and nothing in flight, an accepted write reaches its slow output by the SYNC_STAGES+1'th slow edge after the fast edge that follows acceptance. The busy bit is clear once the slow side has acknowledged.
- R4: While `freeze` is high, writes are accepted without stalling (even to a busy register, the last value wins) and their busy bits rise. No slow output changes.
- R5: When `freeze` falls, every register written during the freeze updates its slow output on the same slow clock edge.
- R6: Bit RST_BIT (default 0) of an accepted configuration write appears on `cnt_rst` after the next fast edge, even while frozen. The configuration busy bit is still set.
- R7: A limit write followed by a configuration write, freeze low, updates `s_limit` no later than `s_cfg`.
- R8: With `freeze` low, a write to a register whose busy bit is set sees `wr_ready` low and is not taken. It is taken once the bit clears.
- R9: A command write appears on `s_cmd` for exactly one slow cycle and then returns to 0. The other slow outputs are unchanged by it.
- R10: A write with `wr_sel` = 3 is ignored: no busy bit rises and no slow output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fclk | input | 1 | Fast bus clock |
| frst_n | input | 1 | Fast-domain async reset, active low |
| wr_en | input | 1 | Register write request |
| wr_sel | input | 2 | Register select (0 cfg, 1 cmd, 2 limit) |
| wr_data | input | DATA_W | Write data, low bits used per register |
| freeze | input | 1 | Stage writes without crossing |
| wr_ready | output | 1 | Write accepted this edge when high |
| busy | output | 3 | Per-register pending flags |
| cnt_rst | output | 1 | Counter reset, bypassing the crossing |
| sclk | input | 1 | Slow peripheral clock |
| srst_n | input | 1 | Slow-domain async reset, active low |
| s_cfg | output | CFG_W | Configuration word in slow domain |
| s_cmd | output | CMD_W | Command pulses in slow domain |
| s_limit | output | LIM_W | Limit word in slow domain |

## Verification
Suppose the pending set or the in-flight mask is wrong inside the bridge. The busy flags then either never fall, which the bench sees as a register that never goes idle, or they fall while the slow output still shows the old value, which is caught a few slow cycles later. If a launch ignores freeze, a slow output changes during the hold window. If pending registers are split across transfers, the configuration and limit outputs change on different slow edges after release. Both show up within one transfer time. If the command auto-clear is missing, a second nonzero command cycle appears on the very next slow edge.

// File: rtl/xrb_pkg.sv
package xrb_pkg;
   localparam int XRB_NREG  = 3;
   localparam int IDX_CFG   = 0;
   localparam int IDX_CMD   = 1;
   localparam int IDX_LIMIT = 2;
endpackage

// File: rtl/xrb_sync.sv
module xrb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("xrb_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xrb_fast_side.sv
module xrb_fast_side
   import xrb_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int CFG_W   = 8,
   parameter int CMD_W   = 4,
   parameter int LIM_W   = 16,
   parameter int RST_BIT = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_sel,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                freeze,
   output logic                wr_ready,
   output logic [XRB_NREG-1:0] busy,
   output logic                cnt_rst,
   output logic                req_tgl,
   input  logic                ack_s,
   output logic [XRB_NREG-1:0] hold_mask,
   output logic [CFG_W-1:0]    hold_cfg,
   output logic [CMD_W-1:0]    hold_cmd,
   output logic [LIM_W-1:0]    hold_limit
);
   localparam int NR = XRB_NREG;

   logic [NR-1:0]    hit, acc, pend_q, busy_w;
   logic [CFG_W-1:0] sh_cfg;
   logic [CMD_W-1:0] sh_cmd;
   logic [LIM_W-1:0] sh_limit;
   logic             req_q, inflight, launch, rdy;

   always_comb begin
      for (int i = 0; i < NR; i++) hit[i] = wr_en && (wr_sel == 2'(i));
   end

   assign inflight = req_q ^ ack_s;
   assign busy_w   = pend_q | (inflight ? hold_mask : '0);
   assign rdy      = freeze || ((hit & busy_w) == '0);
   assign acc      = rdy ? hit : '0;
   assign launch   = !freeze && !inflight && (pend_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_cfg   <= '0;
         sh_cmd   <= '0;
         sh_limit <= '0;
      end else begin
         if (acc[IDX_CFG])   sh_cfg   <= wr_data[CFG_W-1:0];
         if (acc[IDX_LIMIT]) sh_limit <= wr_data[LIM_W-1:0];
         if (acc[IDX_CMD])   sh_cmd   <= wr_data[CMD_W-1:0];
         else if (launch && pend_q[IDX_CMD]) sh_cmd <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= '0;
         req_q      <= 1'b0;
         hold_mask  <= '0;
         hold_cfg   <= '0;
         hold_cmd   <= '0;
         hold_limit <= '0;
      end else begin
         pend_q <= (launch ? '0 : pend_q) | acc;
         if (launch) begin
            req_q     <= ~req_q;
            hold_mask <= pend_q;
            if (pend_q[IDX_CFG])   hold_cfg   <= sh_cfg;
            if (pend_q[IDX_CMD])   hold_cmd   <= sh_cmd;
            if (pend_q[IDX_LIMIT]) hold_limit <= sh_limit;
         end
      end
   end

   assign wr_ready = rdy;
   assign busy     = busy_w;
   assign cnt_rst  = sh_cfg[RST_BIT];
   assign req_tgl  = req_q;

   a_r2_write_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (acc != '0) |=> ((busy_w & $past(acc)) == $past(acc)));

   a_r8_stalled_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      ((hit != '0) && !rdy) |=> ($stable(sh_cfg) && $stable(sh_limit)));

   a_r4_freeze_blocks_launch: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> $stable(req_q));

   a_r3_hold_stable_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      inflight |=> (!inflight || ($stable(hold_cfg) && $stable(hold_limit)
                                  && $stable(hold_cmd) && $stable(hold_mask))));

   a_r6_reset_bit_direct: assert property (@(posedge clk) disable iff (!rst_n)
      acc[IDX_CFG] |=> (cnt_rst == $past(wr_data[RST_BIT])));
endmodule

// File: rtl/xrb_slow_side.sv
module xrb_slow_side
   import xrb_pkg::*;
#(
   parameter int CFG_W = 8,
   parameter int CMD_W = 4,
   parameter int LIM_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_s,
   input  logic [XRB_NREG-1:0] hold_mask,
   input  logic [CFG_W-1:0]    hold_cfg,
   input  logic [CMD_W-1:0]    hold_cmd,
   input  logic [LIM_W-1:0]    hold_limit,
   output logic                ack_tgl,
   output logic [CFG_W-1:0]    s_cfg,
   output logic [CMD_W-1:0]    s_cmd,
   output logic [LIM_W-1:0]    s_limit
);
   logic seen_q, apply;

   assign apply = req_s ^ seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q  <= 1'b0;
         s_cfg   <= '0;
         s_cmd   <= '0;
         s_limit <= '0;
      end else begin
         seen_q <= req_s;
         s_cmd  <= (apply && hold_mask[IDX_CMD]) ? hold_cmd : '0;
         if (apply && hold_mask[IDX_CFG])   s_cfg   <= hold_cfg;
         if (apply && hold_mask[IDX_LIMIT]) s_limit <= hold_limit;
      end
   end

   assign ack_tgl = seen_q;

   a_r9_cmd_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (s_cmd != '0) |=> (s_cmd == '0));

   a_r3_update_only_on_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      !apply |=> ($stable(s_cfg) && $stable(s_limit)));
endmodule

// File: rtl/xrb_bridge.sv
module xrb_bridge
   import xrb_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int CFG_W       = 8,
   parameter int CMD_W       = 4,
   parameter int LIM_W       = 16,
   parameter int RST_BIT     = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic                fclk,
   input  logic                frst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_sel,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                freeze,
   output logic                wr_ready,
   output logic [XRB_NREG-1:0] busy,
   output logic                cnt_rst,
   input  logic                sclk,
   input  logic                srst_n,
   output logic [CFG_W-1:0]    s_cfg,
   output logic [CMD_W-1:0]    s_cmd,
   output logic [LIM_W-1:0]    s_limit
);
   generate
      if (CFG_W > DATA_W || CMD_W > DATA_W || LIM_W > DATA_W) begin : g_bad_width
         $error("xrb_bridge: register width exceeds DATA_W");
      end
      if (RST_BIT >= CFG_W) begin : g_bad_rst
         $error("xrb_bridge: RST_BIT outside configuration word");
      end
   endgenerate

   logic                req_tgl, req_s, ack_tgl, ack_s;
   logic [XRB_NREG-1:0] hold_mask;
   logic [CFG_W-1:0]    hold_cfg;
   logic [CMD_W-1:0]    hold_cmd;
   logic [LIM_W-1:0]    hold_limit;

   xrb_fast_side #(
      .DATA_W(DATA_W), .CFG_W(CFG_W), .CMD_W(CMD_W), .LIM_W(LIM_W), .RST_BIT(RST_BIT)
   ) u_fast (
      .clk(fclk), .rst_n(frst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .freeze(freeze), .wr_ready(wr_ready), .busy(busy), .cnt_rst(cnt_rst),
      .req_tgl(req_tgl), .ack_s(ack_s), .hold_mask(hold_mask), .hold_cfg(hold_cfg),
      .hold_cmd(hold_cmd), .hold_limit(hold_limit)
   );

   xrb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(sclk), .rst_n(srst_n), .d(req_tgl), .q(req_s)
   );

   xrb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(fclk), .rst_n(frst_n), .d(ack_tgl), .q(ack_s)
   );

   xrb_slow_side #(.CFG_W(CFG_W), .CMD_W(CMD_W), .LIM_W(LIM_W)) u_slow (
      .clk(sclk), .rst_n(srst_n), .req_s(req_s), .hold_mask(hold_mask),
      .hold_cfg(hold_cfg), .hold_cmd(hold_cmd), .hold_limit(hold_limit),
      .ack_tgl(ack_tgl), .s_cfg(s_cfg), .s_cmd(s_cmd), .s_limit(s_limit)
   );
endmodule

// File: tb/xrb_bridge_tb.sv
`timescale 1ns/10ps
module xrb_bridge_tb;
   localparam int DATA_W = 16, CFG_W = 8, CMD_W = 4, LIM_W = 16, STG = 2;

   logic fclk = 0, sclk = 0, frst_n = 0, srst_n = 0;
   logic wr_en = 0, freeze = 0;
   logic [1:0] wr_sel = 0;
   logic [DATA_W-1:0] wr_data = 0;
   logic wr_ready, cnt_rst;
   logic [2:0] busy;
   logic [CFG_W-1:0] s_cfg;
   logic [CMD_W-1:0] s_cmd;
   logic [LIM_W-1:0] s_limit;

   int vectors = 0, miscompares = 0, fcyc = 0, scyc = 0;
   int cfg_chg = 0, lim_chg = 0, cmd_cnt = 0;
   logic [CMD_W-1:0] cmd_last = 0;
   logic [CFG_W-1:0] prev_cfg = 0;
   logic [LIM_W-1:0] prev_lim = 0;

   always #5 fclk = ~fclk;
   initial begin #1.1; forever #16.25 sclk = ~sclk; end

   xrb_bridge #(.DATA_W(DATA_W), .CFG_W(CFG_W), .CMD_W(CMD_W), .LIM_W(LIM_W),
                .RST_BIT(0), .SYNC_STAGES(STG)) u_dut (
      .fclk(fclk), .frst_n(frst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .freeze(freeze), .wr_ready(wr_ready), .busy(busy), .cnt_rst(cnt_rst),
      .sclk(sclk), .srst_n(srst_n), .s_cfg(s_cfg), .s_cmd(s_cmd), .s_limit(s_limit));

   always @(negedge sclk) begin
      scyc++;
      if (s_cfg !== prev_cfg) cfg_chg = scyc;
      if (s_limit !== prev_lim) lim_chg = scyc;
      prev_cfg = s_cfg;
      prev_lim = s_limit;
      if (s_cmd != 0) begin cmd_cnt++; cmd_last = s_cmd; end
   end

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   always @(posedge fclk) begin
      fcyc++;
      if (fcyc > 150000) begin
         miscompares++;
         $display("FAIL watchdog act=%0d exp<150000", fcyc);
         summary();
         $finish;
      end
   end

   function automatic logic [2:0] sel_bit(input int sel);
      return (sel < 3) ? 3'(1 << sel) : 3'b000;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int sel, input logic [DATA_W-1:0] d, output int stalls);
      stalls = 0;
      @(negedge fclk);
      wr_en = 1; wr_sel = 2'(sel); wr_data = d;
      #1;
      while (!wr_ready && stalls < 500) begin
         @(negedge fclk); #1; stalls++;
      end
      @(posedge fclk); #1;
      wr_en = 0;
   endtask

   task automatic wait_idle(input string tag);
      int n = 0;
      @(negedge fclk);
      while (busy != 0 && n < 500) begin @(negedge fclk); n++; end
      chk({tag, " idle"}, 32'(busy), 32'h0);
   endtask

   task automatic slow_wait(input int n);
      for (int i = 0; i < n; i++) @(negedge sclk);
   endtask

   initial begin
      int st;
      int c0, l0, c_snap;
      logic [CFG_W-1:0] exp_cfg = 0;
      logic [LIM_W-1:0] exp_lim = 0;
      void'($urandom(32'h5eed_0c0d));

      repeat (5) @(negedge fclk);
      frst_n = 1; srst_n = 1;
      @(negedge fclk);
      // R1 reset state
      chk("R1 busy", 32'(busy), 0);
      chk("R1 ready", 32'(wr_ready), 1);
      chk("R1 cnt_rst", 32'(cnt_rst), 0);
      chk("R1 outputs", {s_cfg, s_cmd, s_limit}, 0);

      // R2 + R3: single limit write, bounded latency
      wr(2, 16'h1234, st);
      chk("R2 busy limit", 32'(busy), 32'(sel_bit(2)));
      @(posedge fclk);
      repeat (STG + 1) @(posedge sclk);
      #1;
      chk("R3 latency", 32'(s_limit), 32'h1234);
      wait_idle("R3");
      exp_lim = 16'h1234;

      // R9: command pulse, other outputs untouched
      cmd_cnt = 0;
      wr(1, 16'h000A, st);
      chk("R2 busy cmd", 32'(busy), 32'(sel_bit(1)));
      wait_idle("R9");
      slow_wait(4);
      chk("R9 pulse count", 32'(cmd_cnt), 1);
      chk("R9 pulse value", 32'(cmd_last), 32'hA);
      chk("R9 limit kept", 32'(s_limit), 32'h1234);
      chk("R9 cfg kept", 32'(s_cfg), 0);

      // R4/R5/R6: freeze staging and batched release
      @(negedge fclk); freeze = 1;
      wr(0, 16'h0010, st);
      chk("R6 cnt_rst low", 32'(cnt_rst), 0);
      wr(0, 16'h005B, st);
      chk("R4 no stall frozen", 32'(st), 0);
      chk("R6 cnt_rst bypass", 32'(cnt_rst), 1);
      wr(2, 16'hBEEF, st);
      repeat (20) @(negedge fclk);
      chk("R4 busy frozen", 32'(busy), 32'b101);
      chk("R4 cfg held", 32'(s_cfg), 0);
      chk("R4 limit held", 32'(s_limit), 32'h1234);
      @(negedge fclk); freeze = 0;
      wait_idle("R5");
      slow_wait(2);
      chk("R5 cfg", 32'(s_cfg), 32'h5B);
      chk("R5 limit", 32'(s_limit), 32'hBEEF);
      chk("R5 same edge", 32'(cfg_chg), 32'(lim_chg));
      exp_cfg = 8'h5B; exp_lim = 16'hBEEF;

      // R7: ordering limit then cfg
      c0 = cfg_chg; l0 = lim_chg;
      wr(2, 16'h0042, st);
      wr(0, 16'h0080, st);
      wait_idle("R7");
      slow_wait(2);
      chk("R7 both moved", 32'((cfg_chg != c0) && (lim_chg != l0)), 1);
      chk("R7 order", 32'(lim_chg <= cfg_chg), 1);
      chk("R6 cnt_rst cleared", 32'(cnt_rst), 0);
      exp_cfg = 8'h80; exp_lim = 16'h0042;

      // R8: back-to-back limit writes stall
      wr(2, 16'h7777, st);
      wr(2, 16'h8888, st);
      chk("R8 stalled", 32'(st > 0), 1);
      chk("R8 stall bounded", 32'(st < 500), 1);
      wait_idle("R8");
      slow_wait(2);
      chk("R8 last value", 32'(s_limit), 32'h8888);
      exp_lim = 16'h8888;

      // R10: unused select ignored
      cmd_cnt = 0; c_snap = scyc;
      wr(3, 16'hFFFF, st);
      chk("R10 no stall", 32'(st), 0);
      chk("R10 busy", 32'(busy), 0);
      slow_wait(6);
      chk("R10 cfg", 32'(s_cfg), 32'(exp_cfg));
      chk("R10 limit", 32'(s_limit), 32'(exp_lim));
      chk("R10 cmd", 32'(cmd_cnt), 0);
      chk("R10 slow ran", 32'(scyc > c_snap), 1);

      // Random mix against model
      for (int i = 0; i < 160; i++) begin
         int sel = int'($urandom_range(0, 3));
         logic [DATA_W-1:0] d = DATA_W'($urandom);
         if ($urandom_range(0, 5) == 0) begin @(negedge fclk); freeze = ~freeze; end
         wr(sel, d, st);
         if (sel < 3) chk("R2 random busy", 32'(busy & sel_bit(sel)), 32'(sel_bit(sel)));
         if (sel == 0) begin
            exp_cfg = d[CFG_W-1:0];
            chk("R6 random cnt_rst", 32'(cnt_rst), 32'(d[0]));
         end
         if (sel == 2) exp_lim = d[LIM_W-1:0];
         if (i % 10 == 9) begin
            @(negedge fclk); freeze = 0;
            wait_idle("R3 random");
            slow_wait(2);
            chk("R3 random cfg", 32'(s_cfg), 32'(exp_cfg));
            chk("R3 random limit", 32'(s_limit), 32'(exp_lim));
         end
      end

      summary();
      $finish;
   end
endmodule